// File: doc/BRIEF.md
# Interrupt-Capable General-Purpose Pin Port

This block is a memory-mapped controller for one port of general-purpose pins, eight by default. Every pin has its own 32-byte register window. In that window a configuration word sets enable, direction, trigger kind, trigger polarity and interrupt enable. Further registers hold a debounce threshold, the filtered input level, a float control, the driven output level and a write-only clear for the pin's pending interrupt. The pad input is synchronised and then debounced. From the filtered level the pin detects level, single-edge or double-edge events and records a pending flag.

A port-wide status word at offset 0x104 shows the pending flag of every pin that has both its enable and its interrupt-enable bits set. The OR of that word drives the single port interrupt line. Software talks to the block over a plain 32-bit register bus. Reads are combinational and writes take effect on the clock edge. The pad side is a set of input, output-level and output-enable vectors.

Top module: `gpio_trig_port`

## Requirements
- R1: After reset every register reads 0, every pin is disabled, pad_oe is all zero, the status word is 0 and irq_out is 0.
- R2: Pin n's window starts at n*0x20. Offset 0x00 is the configuration word: bit 0 enable, bit 1 output direction, bits 3:2 trigger kind (0 none, 1 level, 2 single edge, 3 double edge), bit 4 polarity, bit 6 interrupt enable; all other bits read 0. Offset 0x04 holds the debounce threshold in bits 7:0. Offset 0x0C bit 0 is float. Offset 0x10 bit 0 is the output level. Each of these reads back what was last written.
- R3: pad_oe[n] is 1 only when pin n is enabled, its direction bit is 1 and its float bit is 0. pad_out[n] always equals the pin's output-level bit.
- R4: Bit 0 of offset 0x08 is the filtered pad level. The pad passes two synchroniser flops and the filter register. With a threshold of 0, a pad change is visible after the third rising clock edge and not after the second.
- R5: With a nonzero threshold T, a new synchronised level is accepted only after it has been seen on T+1 consecutive clock edges. A shorter pulse leaves the filtered level unchanged.
- R6: Single-edge kind with polarity 1 sets pending on a rising filtered edge. With polarity 0 it sets pending on a falling filtered edge. The flag stays set until it is cleared.
- R7: Double-edge kind sets pending on both edges, whatever the polarity.
- R8: In level kind the pending flag is 1 exactly while the filtered level equals the polarity. A clear write does not drop it while that level holds, and the flag falls without a clear once the level leaves.
- R9: Writing a value with bit 0 set to offset 0x14 clears an edge-kind pending flag. Writing a value with bit 0 clear there changes nothing.
- R10: Status bit n at offset 0x104 equals pin n's pending flag ANDed with its enable and its interrupt-enable bits. irq_out is the OR of the status bits.
- R11: A pin that is disabled, or whose trigger kind is none, records no new pending flag on pad edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Bus access select |
| bus_wr | input | 1 | 1 for write, 0 for read |
| bus_addr | input | ADDR_W (12) | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from bus_addr |
| pad_in | input | NUM_PINS (8) | Pad input levels, asynchronous |
| pad_out | output | NUM_PINS (8) | Levels to drive on the pads |
| pad_oe | output | NUM_PINS (8) | Pad output enables |
| irq_out | output | 1 | Port interrupt |

## Verification
The bench uses the defaults: eight pins, a 12-bit address, an 8-bit debounce threshold and two synchroniser stages. Eight pins fill the whole 0x00 to 0xFF window space, so the highest pin index and its status bit are both exercised. The 8-bit threshold lets a debounce of 3 be set, which puts a rejected short pulse and an accepted long one within a few cycles. Random pad patterns across all eight pins, with a random trigger kind and polarity per pin, run against a bench model of pending flags and interleaved clears.

// File: rtl/gpt_pkg.sv
package gpt_pkg;

  localparam int WIN_BITS = 5;

  localparam logic [WIN_BITS-1:0] OFF_CFG  = 5'h00;
  localparam logic [WIN_BITS-1:0] OFF_DEB  = 5'h04;
  localparam logic [WIN_BITS-1:0] OFF_IN   = 5'h08;
  localparam logic [WIN_BITS-1:0] OFF_OCTL = 5'h0C;
  localparam logic [WIN_BITS-1:0] OFF_OVAL = 5'h10;
  localparam logic [WIN_BITS-1:0] OFF_CLR  = 5'h14;

  typedef enum logic [1:0] {
    TRIG_NONE  = 2'd0,
    TRIG_LEVEL = 2'd1,
    TRIG_EDGE  = 2'd2,
    TRIG_BOTH  = 2'd3
  } trig_e;

  typedef struct packed {
    logic  irq_en;
    logic  pol;
    trig_e trig;
    logic  dir_out;
    logic  en;
  } pin_cfg_t;

  function automatic logic [7:0] cfg_pack(pin_cfg_t c);
    return {1'b0, c.irq_en, 1'b0, c.pol, c.trig, c.dir_out, c.en};
  endfunction

  function automatic pin_cfg_t cfg_unpack(logic [7:0] w);
    pin_cfg_t c;
    c.en      = w[0];
    c.dir_out = w[1];
    c.trig    = trig_e'(w[3:2]);
    c.pol     = w[4];
    c.irq_en  = w[6];
    return c;
  endfunction

  // Debounce acceptance: level differs and the hold count reached the threshold.
  function automatic logic deb_accept(logic diff, logic [15:0] cnt, logic [15:0] thr);
    return diff && (cnt >= thr);
  endfunction

  // Edge event from filtered level cur moving to nx.
  function automatic logic edge_hit(trig_e t, logic pol, logic cur, logic nx);
    case (t)
      TRIG_EDGE: return (cur != nx) && (nx == pol);
      TRIG_BOTH: return cur != nx;
      default:   return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/gpt_filter.sv
module gpt_filter #(
  parameter int DEB_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pad_i,
  input  logic [DEB_W-1:0] thr_i,
  output logic             level_o,
  output logic             level_nx_o,
  output logic             accept_o
);
  import gpt_pkg::*;

  logic [SYNC_STAGES-1:0] sync_q;
  logic [DEB_W-1:0]       cnt_q;
  logic                   level_q;
  logic                   synced;

  assign synced = sync_q[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[SYNC_STAGES-2:0], pad_i};
  end

  assign accept_o   = deb_accept(synced != level_q, 16'(cnt_q), 16'(thr_i));
  assign level_nx_o = accept_o ? synced : level_q;
  assign level_o    = level_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      level_q <= 1'b0;
    end else begin
      level_q <= level_nx_o;
      if (synced == level_q || accept_o) cnt_q <= '0;
      else                               cnt_q <= cnt_q + 1'b1;
    end
  end

  AST_DEB_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(level_q) |-> $past(cnt_q >= thr_i)) else $error("debounce early accept"); // R5

endmodule

// File: rtl/gpt_pin.sv
module gpt_pin #(
  parameter int DEB_W       = 8,
  parameter int SYNC_STAGES = 2,
  parameter int WD_W        = 8
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         pad_i,
  input  logic                         wr_i,
  input  logic [gpt_pkg::WIN_BITS-1:0] off_i,
  input  logic [WD_W-1:0]              wdata_i,
  output logic [31:0]                  rdata_o,
  output logic                         pad_o,
  output logic                         pad_oe_o,
  output logic                         pend_o,
  output logic                         gate_o
);
  import gpt_pkg::*;

  pin_cfg_t         cfg_q;
  logic [DEB_W-1:0] thr_q;
  logic             float_q;
  logic             oval_q;
  logic             pend_q;
  logic             level, level_nx, accept;
  logic             clr_stb;
  logic             hit;

  gpt_filter #(.DEB_W(DEB_W), .SYNC_STAGES(SYNC_STAGES)) u_filt (
    .clk       (clk),
    .rst_n     (rst_n),
    .pad_i     (pad_i),
    .thr_i     (thr_q),
    .level_o   (level),
    .level_nx_o(level_nx),
    .accept_o  (accept)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q   <= '0;
      thr_q   <= '0;
      float_q <= 1'b0;
      oval_q  <= 1'b0;
    end else if (wr_i) begin
      case (off_i)
        OFF_CFG:  cfg_q   <= cfg_unpack(wdata_i[7:0]);
        OFF_DEB:  thr_q   <= wdata_i[DEB_W-1:0];
        OFF_OCTL: float_q <= wdata_i[0];
        OFF_OVAL: oval_q  <= wdata_i[0];
        default:  ;
      endcase
    end
  end

  assign clr_stb = wr_i && (off_i == OFF_CLR) && wdata_i[0];
  assign hit     = cfg_q.en && accept && edge_hit(cfg_q.trig, cfg_q.pol, level, level_nx);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                        pend_q <= 1'b0;
    else if (cfg_q.trig == TRIG_LEVEL) pend_q <= cfg_q.en && (level_nx == cfg_q.pol);
    else                               pend_q <= (pend_q && !clr_stb) || hit;
  end

  always_comb begin
    case (off_i)
      OFF_CFG:  rdata_o = 32'(cfg_pack(cfg_q));
      OFF_DEB:  rdata_o = 32'(thr_q);
      OFF_IN:   rdata_o = 32'(level);
      OFF_OCTL: rdata_o = 32'(float_q);
      OFF_OVAL: rdata_o = 32'(oval_q);
      default:  rdata_o = 32'd0;
    endcase
  end

  assign pad_o    = oval_q;
  assign pad_oe_o = cfg_q.en && cfg_q.dir_out && !float_q;
  assign pend_o   = pend_q;
  assign gate_o   = cfg_q.en && cfg_q.irq_en;

  AST_FLOAT_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_i && off_i == OFF_OCTL && wdata_i[0]) |=> !pad_oe_o) else $error("pad driven while floated"); // R3
  AST_EDGE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && !clr_stb && cfg_q.trig != TRIG_LEVEL) |=> (pend_q || cfg_q.trig == TRIG_LEVEL)) else $error("edge pending lost"); // R6
  AST_CLR_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_stb && !hit && cfg_q.trig != TRIG_LEVEL) |=> (!pend_q || cfg_q.trig == TRIG_LEVEL)) else $error("clear ignored"); // R9
  AST_NO_EVENT_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (!pend_q && (!cfg_q.en || cfg_q.trig == TRIG_NONE)) |=> !pend_q) else $error("pending while inactive"); // R11

endmodule

// File: rtl/gpio_trig_port.sv
module gpio_trig_port #(
  parameter int NUM_PINS    = 8,
  parameter int ADDR_W      = 12,
  parameter int DEB_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bus_sel,
  input  logic                bus_wr,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [31:0]         bus_wdata,
  output logic [31:0]         bus_rdata,
  input  logic [NUM_PINS-1:0] pad_in,
  output logic [NUM_PINS-1:0] pad_out,
  output logic [NUM_PINS-1:0] pad_oe,
  output logic                irq_out
);
  import gpt_pkg::*;

  localparam int PIDX_W   = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1;
  localparam int WIN_SIZE = 1 << WIN_BITS;
  localparam int WD_W     = (DEB_W > 8) ? DEB_W : 8;
  localparam logic [ADDR_W-1:0] WIN_END   = ADDR_W'(NUM_PINS * WIN_SIZE);
  localparam logic [ADDR_W-1:0] STAT_ADDR = ADDR_W'(12'h104);

  logic                in_win;
  logic [PIDX_W-1:0]   pin_idx;
  logic [WIN_BITS-1:0] off;
  logic [31:0]         pin_rd [NUM_PINS];
  logic [NUM_PINS-1:0] pend, gate, status;
  logic                unused_wdata;

  assign in_win       = bus_addr < WIN_END;
  assign pin_idx      = bus_addr[WIN_BITS +: PIDX_W];
  assign off          = bus_addr[WIN_BITS-1:0];
  assign unused_wdata = ^bus_wdata[31:WD_W];

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
    logic wr_sel;
    assign wr_sel = bus_sel && bus_wr && in_win && (pin_idx == PIDX_W'(i));
    gpt_pin #(.DEB_W(DEB_W), .SYNC_STAGES(SYNC_STAGES), .WD_W(WD_W)) u_pin (
      .clk     (clk),
      .rst_n   (rst_n),
      .pad_i   (pad_in[i]),
      .wr_i    (wr_sel),
      .off_i   (off),
      .wdata_i (bus_wdata[WD_W-1:0]),
      .rdata_o (pin_rd[i]),
      .pad_o   (pad_out[i]),
      .pad_oe_o(pad_oe[i]),
      .pend_o  (pend[i]),
      .gate_o  (gate[i])
    );
  end

  assign status  = pend & gate;
  assign irq_out = |status;

  always_comb begin
    if (bus_addr == STAT_ADDR)                   bus_rdata = 32'(status);
    else if (in_win && (32'(pin_idx) < NUM_PINS)) bus_rdata = pin_rd[pin_idx];
    else                                         bus_rdata = 32'd0;
  end

  AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out |-> (|gate)) else $error("irq without enabled pin"); // R10
  AST_IRQ_FROM_PEND: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out |-> (|pend)) else $error("irq without pending pin"); // R10

endmodule

// File: tb/gpio_trig_port_tb.sv
`timescale 1ns/1ps
module gpio_trig_port_tb_top;

  localparam int NP = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0;
  logic        bus_wr = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [NP-1:0] pad_in = '0;
  logic [NP-1:0] pad_out, pad_oe;
  logic        irq_out;

  int n_chk = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  gpio_trig_port dut_i (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe), .irq_out(irq_out)
  );

  function automatic logic [11:0] a_of(int pin, int off);
    return 12'(pin * 32 + off);
  endfunction

  // Bench view of a pending flag after the filtered level moves old -> nw.
  function automatic logic model_pend(int kind, logic pol, logic old, logic nw, logic prev);
    if (kind == 1) return nw == pol;
    if (kind == 2) return prev | ((old ^ nw) & ~(nw ^ pol));
    if (kind == 3) return prev | (old ^ nw);
    return prev;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [11:0] a, logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd(logic [11:0] a, output logic [31:0] d);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    bus_sel = 1'b0;
  endtask

  task automatic wait_n(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_pad(int i, logic v);
    @(negedge clk);
    pad_in[i] = v;
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #1_000_000;
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    logic [31:0] d;
    int kind [NP];
    logic pol [NP];
    logic [NP-1:0] mp, oldp, newp;
    void'($urandom(32'd20240611));

    wait_n(3);
    rst_n = 1'b1;
    wait_n(1);

    // R1 reset state
    rd(a_of(0, 0), d); chk("R1 cfg0", d, 0);
    rd(a_of(7, 4), d); chk("R1 deb7", d, 0);
    rd(12'h104, d);    chk("R1 status", d, 0);
    chk("R1 pad_oe", 32'(pad_oe), 0);
    chk("R1 irq", 32'(irq_out), 0);

    // R2 register readback on pin 3
    wr(a_of(3, 0), 32'hFFFF_FFFF);
    rd(a_of(3, 0), d); chk("R2 cfg bits", d, 32'h5F);
    wr(a_of(3, 4), 32'h0000_01A5);
    rd(a_of(3, 4), d); chk("R2 debounce", d, 32'hA5);
    wr(a_of(3, 12), 32'h3);
    rd(a_of(3, 12), d); chk("R2 float", d, 1);
    wr(a_of(3, 16), 32'hFFFF_FFFE);
    rd(a_of(3, 16), d); chk("R2 outval", d, 0);
    wr(a_of(3, 0), 0); wr(a_of(3, 4), 0); wr(a_of(3, 12), 0);

    // R3 output enable gating on pin 2
    wr(a_of(2, 16), 1);
    wr(a_of(2, 0), 32'h3);
    chk("R3 oe driven", 32'(pad_oe[2]), 1);
    chk("R3 level", 32'(pad_out[2]), 1);
    wr(a_of(2, 12), 1);
    chk("R3 oe floated", 32'(pad_oe[2]), 0);
    wr(a_of(2, 12), 0);
    wr(a_of(2, 0), 32'h1);
    chk("R3 oe input dir", 32'(pad_oe[2]), 0);
    wr(a_of(2, 0), 0);

    // R4 input latency with threshold 0 on pin 1
    set_pad(1, 1'b1);
    wait_n(2); rd(a_of(1, 8), d); chk("R4 after 2 edges", d, 0);
    wait_n(1); rd(a_of(1, 8), d); chk("R4 after 3 edges", d, 1);

    // R5 debounce threshold 3 on pin 0
    wr(a_of(0, 4), 3);
    set_pad(0, 1'b1); wait_n(2); pad_in[0] = 1'b0;
    wait_n(10); rd(a_of(0, 8), d); chk("R5 short pulse", d, 0);
    set_pad(0, 1'b1);
    wait_n(5); rd(a_of(0, 8), d); chk("R5 before T+1", d, 0);
    wait_n(1); rd(a_of(0, 8), d); chk("R5 at T+1", d, 1);

    // R6 single edge, R9 clear on pin 4
    wr(a_of(4, 0), 32'h59);
    set_pad(4, 1'b1); wait_n(3);
    rd(12'h104, d); chk("R6 rising pending", d, 32'h10);
    chk("R10 irq", 32'(irq_out), 1);
    set_pad(4, 1'b0); wait_n(3);
    rd(12'h104, d); chk("R6 sticky", d, 32'h10);
    wr(a_of(4, 20), 32'hFFFF_FFFE);
    rd(12'h104, d); chk("R9 zero write", d, 32'h10);
    wr(a_of(4, 20), 1);
    rd(12'h104, d); chk("R9 cleared", d, 0);
    chk("R9 irq low", 32'(irq_out), 0);
    wr(a_of(4, 0), 32'h49);
    set_pad(4, 1'b1); wait_n(3);
    rd(12'h104, d); chk("R6 falling ignores rise", d, 0);
    set_pad(4, 1'b0); wait_n(3);
    rd(12'h104, d); chk("R6 falling pending", d, 32'h10);
    wr(a_of(4, 20), 1);

    // R7 double edge, R10 gating on pin 5
    wr(a_of(5, 0), 32'h4D);
    set_pad(5, 1'b1); wait_n(3);
    rd(12'h104, d); chk("R7 rise", d, 32'h20);
    wr(a_of(5, 20), 1);
    set_pad(5, 1'b0); wait_n(3);
    rd(12'h104, d); chk("R7 fall", d, 32'h20);
    wr(a_of(5, 0), 32'h0D);
    rd(12'h104, d); chk("R10 ie off", d, 0);
    chk("R10 irq off", 32'(irq_out), 0);
    wr(a_of(5, 0), 32'h4D);
    rd(12'h104, d); chk("R10 ie back", d, 32'h20);
    wr(a_of(5, 20), 1);

    // R8 level high on pin 6
    wr(a_of(6, 0), 32'h55);
    rd(12'h104, d); chk("R8 inactive low", d, 0);
    set_pad(6, 1'b1); wait_n(3);
    rd(12'h104, d); chk("R8 active", d, 32'h40);
    wr(a_of(6, 20), 1);
    rd(12'h104, d); chk("R8 clear held", d, 32'h40);
    set_pad(6, 1'b0); wait_n(3);
    rd(12'h104, d); chk("R8 follows level", d, 0);

    // R11 disabled and none kinds on pin 7
    wr(a_of(7, 0), 32'h4C);
    set_pad(7, 1'b1); wait_n(3);
    wr(a_of(7, 0), 32'h4D);
    rd(12'h104, d); chk("R11 disabled edge", d, 0);
    wr(a_of(7, 0), 32'h41);
    set_pad(7, 1'b0); wait_n(3);
    rd(12'h104, d); chk("R11 kind none", d, 0);

    // Random phase: R6 R7 R8 R9 R10 across all pins
    pad_in = '0;
    wait_n(6);
    for (int i = 0; i < NP; i++) begin
      kind[i] = int'($urandom % 4);
      pol[i]  = 1'($urandom % 2);
      wr(a_of(i, 4), 0);
      wr(a_of(i, 0), 32'h41 | (32'(kind[i]) << 2) | (32'(pol[i]) << 4));
    end
    for (int i = 0; i < NP; i++) wr(a_of(i, 20), 1);
    for (int i = 0; i < NP; i++) mp[i] = (kind[i] == 1) ? (pol[i] == 1'b0) : 1'b0;
    rd(12'h104, d); chk("R10 random start", d, 32'(mp));
    oldp = '0;
    for (int it = 0; it < 40; it++) begin
      newp = NP'($urandom);
      @(negedge clk); pad_in = newp;
      wait_n(3);
      for (int i = 0; i < NP; i++)
        mp[i] = model_pend(kind[i], pol[i], oldp[i], newp[i], mp[i]);
      oldp = newp;
      rd(12'h104, d); chk("R10 random status", d, 32'(mp));
      chk("R10 random irq", 32'(irq_out), 32'(|mp));
      if (it % 4 == 3) begin
        int k;
        k = int'($urandom % NP);
        wr(a_of(k, 20), 1);
        if (kind[k] != 1) mp[k] = 1'b0;
        rd(12'h104, d); chk("R9 random clear", d, 32'(mp));
      end
    end

    finish_run();
  end

endmodule